// File: doc/BRIEF.md
# Nibble-Access Auto-Reload Timer

An 8-bit up-counting timer for a 4-bit microcontroller data path. Software reaches the timer through a small register interface that is four bits wide. The 8-bit reload value and the live count are therefore moved as two nibbles, and the order of access is part of the behaviour. A write of the high nibble commits the stored low nibble and the new high nibble together, as both the reload value and the counter. A read of the high nibble freezes the low nibble of the count in a latch, so the low-nibble read that follows returns a value that matches the high nibble already returned.

Count events come from one of two sources. The internal source is the instruction clock, which is the block clock divided by four. The external source is a pin, passed through a two-flop synchronizer and an edge detector, and software picks whether rising or falling edges count. The events feed a prescaler with eight selectable ratios, from 1 to 2048. When the counter steps past FF it reloads from the reload register and sets a sticky request flag. That flag is offered to the interrupt logic and, when enabled, is also driven out as a wake-up request.

Register accesses take effect in a single cycle and have no back-pressure. A write is taken on the clock edge where `bus_wr` is high, and read data is valid in the same cycle as `bus_rd`. The port carries no streamed data, so it has no valid/ready pair.

Top module: `nt_timer`

## Requirements
- R1: After reset the count, the reload value, the mode field, the source select, the edge select, the enable and the request flag all read as 0. Mode 0 means a ratio of 2048.
- R2: Address 0 written stores the low reload nibble only. Address 1 written with value H loads both the reload register and the counter with {H, stored low nibble} on that edge.
- R3: Reading address 1 returns count[7:4] and captures count[3:0] in a latch. Reading address 0 returns that latch, even if the counter has moved since.
- R4: A count step taken while the counter holds FF loads the counter from the reload register and sets the request flag.
- R5: Address 2 holds the mode in bits [2:0]. Codes 0 to 7 give prescaler ratios 2048, 512, 128, 32, 8, 4, 2 and 1, so the counter steps once per N source events. A write to address 2 restarts the prescaler from zero.
- R6: With source select 0, the source events are the internal instruction ticks, one every 4 clocks. With ratio 1, the counter advances by about one per 4 clocks.
- R7: Address 3 bit 0 selects the source: 0 is internal, 1 is the pin. Address 3 bit 1 selects the edge: 0 counts rising pin edges, 1 counts falling pin edges. Each pin level must be held for at least 2 clocks.
- R8: Address 4 bit 0 is the request flag and bit 1 is the enable. A write to address 4 with bit 0 = 0 clears the flag, and a write with bit 0 = 1 leaves it as it was. `irq_pending` follows the flag. `wake_req` is the flag AND the enable.
- R9: Address 3 bits [3:2] and address 4 bits [3:2] read as 0, and addresses 5 to 7 read as 0. `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block (oscillator) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 4 | Write data nibble |
| bus_rdata | output | 4 | Read data nibble, same cycle as bus_rd |
| tmr_pin | input | 1 | External count input |
| irq_pending | output | 1 | Sticky overflow request flag |
| wake_req | output | 1 | Request flag gated by the enable |

## Verification
The hardest situation to reach is a ratio boundary that lies far away: the 2048th event at the slowest ratio, together with the point just before it. The stimulus drives the pin source with exactly 2047 clean edges after a mode write, checks that the count has not moved, and then gives one more edge. The latch case needs the counter to move between the two halves of a read, so a pin edge is placed between the high-nibble read and the low-nibble read. Wrap-around is reached quickly by committing a reload of FE and then stepping the counter one pin edge at a time.

// File: rtl/nt_pkg.sv
package nt_pkg;
  localparam int NT_ADDR_W = 3;
  localparam logic [NT_ADDR_W-1:0] A_LO   = 3'd0;
  localparam logic [NT_ADDR_W-1:0] A_HI   = 3'd1;
  localparam logic [NT_ADDR_W-1:0] A_MODE = 3'd2;
  localparam logic [NT_ADDR_W-1:0] A_CTRL = 3'd3;
  localparam logic [NT_ADDR_W-1:0] A_STAT = 3'd4;

  localparam int NT_MODE_W = 3;

  // prescaler ratio exponent for each mode code (code 0 = slowest)
  function automatic int unsigned ratio_shift(input logic [NT_MODE_W-1:0] code);
    case (code)
      3'd0:    return 11;
      3'd1:    return 9;
      3'd2:    return 7;
      3'd3:    return 5;
      3'd4:    return 3;
      3'd5:    return 2;
      3'd6:    return 1;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/nt_edge_sync.sv
module nt_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic edge_sel,
  output logic ev
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh;
  logic            rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SH_W-2:0], pin};
  end

  assign rise = sh[SH_W-2] & ~sh[SH_W-1];
  assign fall = ~sh[SH_W-2] & sh[SH_W-1];
  assign ev   = edge_sel ? fall : rise;

  // R7: one synchronized edge yields a single-cycle event
  p_single_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && $stable(edge_sel)) |=> !ev);
endmodule

// File: rtl/nt_prescaler.sv
module nt_prescaler
  import nt_pkg::*;
#(
  parameter int PRE_W = 11,
  parameter int DIV_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 src_sel,
  input  logic                 ext_ev,
  input  logic [NT_MODE_W-1:0] mode,
  input  logic                 clr,
  output logic                 step
);
  logic [DIV_W-1:0] div;
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] mask;
  logic             tick_int, src_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div <= '0;
    else        div <= div + 1'b1;
  end

  assign tick_int = &div;
  assign src_tick = src_sel ? ext_ev : tick_int;
  assign mask     = PRE_W'((1 << ratio_shift(mode)) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre <= '0;
    else if (clr)      pre <= '0;
    else if (src_tick) pre <= pre + 1'b1;
  end

  assign step = src_tick && !clr && ((pre & mask) == mask);

  // R5: with any ratio above 1, steps are never back to back
  p_step_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode != 3'd7 && $stable(mode)) |=> !step);
  // R6: internal steps never come closer than 4 clocks apart
  p_int_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !src_sel && $stable(src_sel)) |=> (!step ##1 !step ##1 !step));
endmodule

// File: rtl/nt_count.sv
module nt_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] reload;
  logic             wrap;

  assign wrap = step && !load_en && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      reload <= '0;
    end else if (load_en) begin
      cnt    <= load_val;
      reload <= load_val;
    end else if (wrap) begin
      cnt    <= reload;
    end else if (step) begin
      cnt    <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (wrap)     flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  p_hi_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> cnt == $past(load_val));
  p_wrap_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_en && cnt == CNT_MAX) |=> (cnt == $past(reload) && flag));
  p_count_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_en && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);
  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);
endmodule

// File: rtl/nt_timer.sv
module nt_timer
  import nt_pkg::*;
#(
  parameter int NIB_W       = 4,
  parameter int PRE_W       = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [NT_ADDR_W-1:0] bus_addr,
  input  logic [NIB_W-1:0]     bus_wdata,
  output logic [NIB_W-1:0]     bus_rdata,
  input  logic                 tmr_pin,
  output logic                 irq_pending,
  output logic                 wake_req
);
  localparam int CNT_W = 2 * NIB_W;

  logic [NIB_W-1:0]     reload_lo, rd_latch;
  logic [NT_MODE_W-1:0] mode;
  logic                 src_sel, edge_sel, irq_en;
  logic                 ext_ev, step, flag;
  logic [CNT_W-1:0]     cnt;
  logic                 wr_hi, wr_mode, rd_hi, flag_clr;

  assign wr_hi    = bus_wr && bus_addr == A_HI;
  assign wr_mode  = bus_wr && bus_addr == A_MODE;
  assign rd_hi    = bus_rd && bus_addr == A_HI;
  assign flag_clr = bus_wr && bus_addr == A_STAT && !bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_lo <= '0;
      mode      <= '0;
      src_sel   <= 1'b0;
      edge_sel  <= 1'b0;
      irq_en    <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_LO:    reload_lo <= bus_wdata;
        A_MODE:  mode      <= bus_wdata[NT_MODE_W-1:0];
        A_CTRL:  {edge_sel, src_sel} <= bus_wdata[1:0];
        A_STAT:  irq_en    <= bus_wdata[1];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_latch <= '0;
    else if (rd_hi) rd_latch <= cnt[NIB_W-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_LO:    bus_rdata = rd_latch;
        A_HI:    bus_rdata = cnt[CNT_W-1:NIB_W];
        A_MODE:  bus_rdata = NIB_W'(mode);
        A_CTRL:  bus_rdata = NIB_W'({edge_sel, src_sel});
        A_STAT:  bus_rdata = NIB_W'({irq_en, flag});
        default: bus_rdata = '0;
      endcase
    end
  end

  nt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(tmr_pin), .edge_sel(edge_sel), .ev(ext_ev)
  );

  nt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ext_ev(ext_ev),
    .mode(mode), .clr(wr_mode), .step(step)
  );

  nt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_en(wr_hi),
    .load_val({bus_wdata, reload_lo}), .step(step),
    .flag_clr(flag_clr), .cnt(cnt), .flag(flag)
  );

  assign irq_pending = flag;
  assign wake_req    = flag & irq_en;

  // R3: the low read returns what the counter held at the high read
  p_rdlatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> rd_latch == $past(cnt[NIB_W-1:0]));
  // R8: a write that keeps bit 0 high never clears the flag
  p_keep_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STAT && bus_wdata[0] && irq_pending) |=> irq_pending);
endmodule

// File: tb/nt_timer_bench.sv
module nt_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [3:0] bus_wdata = '0;
  logic [3:0] bus_rdata;
  logic       tmr_pin = 1'b0;
  logic       irq_pending, wake_req;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic [3:0] d;
    bit         care;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  nt_timer u_nt_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_pin(tmr_pin), .irq_pending(irq_pending), .wake_req(wake_req)
  );

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    if (bus_rd) begin
      if (sb.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL scoreboard: read with no expected item, actual %h expected none", bus_rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.care) begin
          n_chk++;
          if (bus_rdata !== e.d) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", e.tag, bus_rdata, e.d);
          end
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [3:0] e, input string tag);
    exp_t it;
    @(posedge clk); #1;
    it.d = e; it.care = 1'b1; it.tag = tag;
    sb.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic rd_raw(input logic [2:0] a, output logic [3:0] v);
    exp_t it;
    @(posedge clk); #1;
    it.d = '0; it.care = 1'b0; it.tag = "raw";
    sb.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); v = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tmr_pin = ~tmr_pin;
      repeat (3) @(posedge clk);
      #1 tmr_pin = ~tmr_pin;
      repeat (2) @(posedge clk);
    end
    repeat (5) @(posedge clk);
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    @(negedge clk);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic rd_cnt(input logic [7:0] e, input string tag);
    rd(3'd1, e[7:4], tag);
    rd(3'd0, e[3:0], tag);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] hi, lo;
    logic [7:0] v;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(3'd2, 4'h0, "R1 mode");
    rd(3'd3, 4'h0, "R1 ctrl");
    rd(3'd4, 4'h0, "R1 status");
    rd_cnt(8'h00, "R1 count");
    // R9 unused addresses, idle bus
    rd(3'd6, 4'h0, "R9 unused addr");
    chk_bit(bus_rdata == 4'h0, 1'b1, "R9 idle rdata");

    // R7 pin source, rising; R5 ratio 1
    wr(3'd3, 4'h1);
    wr(3'd2, 4'h7);
    rd(3'd2, 4'h7, "R5 mode readback");
    rd(3'd3, 4'h1, "R9 ctrl readback");
    // R2 commit on high write
    wr(3'd0, 4'hE);
    wr(3'd1, 4'hF);
    rd_cnt(8'hFE, "R2 commit");
    pulse(1);
    rd_cnt(8'hFF, "R7 rising count");
    // R4 wrap
    pulse(1);
    rd_cnt(8'hFE, "R4 reload on wrap");
    rd(3'd4, 4'h1, "R4 flag set");
    chk_bit(irq_pending, 1'b1, "R8 irq_pending");
    chk_bit(wake_req, 1'b0, "R8 wake gated off");
    // R8 flag sticks
    pulse(1);
    rd(3'd4, 4'h1, "R8 flag holds");
    wr(3'd4, 4'h2);
    rd(3'd4, 4'h2, "R8 flag cleared, enable set");
    chk_bit(wake_req, 1'b0, "R8 wake low after clear");
    pulse(1);
    rd(3'd4, 4'h3, "R8 flag re-set");
    chk_bit(wake_req, 1'b1, "R8 wake high");
    wr(3'd4, 4'h3);
    rd(3'd4, 4'h3, "R8 write bit0=1 keeps flag");
    wr(3'd4, 4'h0);
    chk_bit(wake_req, 1'b0, "R8 wake after clear");
    rd(3'd4, 4'h0, "R8 status cleared");

    // R3 latch across a count change
    rd(3'd1, 4'hF, "R3 high nibble");
    pulse(1);
    rd(3'd0, 4'hE, "R3 latched low");
    rd_cnt(8'hFF, "R3 fresh read");

    // R7 falling edge select
    wr(3'd3, 4'h3);
    wr(3'd0, 4'h0);
    wr(3'd1, 4'h2);
    @(posedge clk); #1 tmr_pin = 1'b1;
    repeat (6) @(posedge clk);
    rd_cnt(8'h20, "R7 rise ignored in falling mode");
    @(posedge clk); #1 tmr_pin = 1'b0;
    repeat (6) @(posedge clk);
    rd_cnt(8'h21, "R7 falling counted");

    // R5 ratios
    wr(3'd3, 4'h1);
    wr(3'd2, 4'h6);
    wr(3'd0, 4'h0);
    wr(3'd1, 4'h3);
    pulse(4);
    rd_cnt(8'h32, "R5 ratio 2");
    wr(3'd2, 4'h5);
    pulse(7);
    rd_cnt(8'h33, "R5 ratio 4 partial");
    pulse(1);
    rd_cnt(8'h34, "R5 ratio 4 boundary");
    wr(3'd2, 4'h4);
    pulse(8);
    rd_cnt(8'h35, "R5 ratio 8");
    wr(3'd2, 4'h0);
    wr(3'd0, 4'h0);
    wr(3'd1, 4'h4);
    pulse(2047);
    rd_cnt(8'h40, "R5 ratio 2048 one short");
    pulse(1);
    rd_cnt(8'h41, "R5 ratio 2048 boundary");

    // R6 internal source
    wr(3'd2, 4'h7);
    wr(3'd0, 4'h0);
    wr(3'd1, 4'h1);
    wr(3'd3, 4'h0);
    repeat (40) @(posedge clk);
    wr(3'd3, 4'h1);
    rd_raw(3'd1, hi);
    rd_raw(3'd0, lo);
    v = {hi, lo};
    n_chk++;
    if (v < 8'h19 || v > 8'h1C) begin
      n_bad++;
      $display("FAIL R6 internal rate: actual %h expected 19..1C", v);
    end

    repeat (4) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule